// File: doc/BRIEF.md
# Shift-Add Second-Order Allpass Section

This block is a second-order recursive allpass stage for fixed-point sample streams. It realises H(z) = (c + z^-2) / (1 + c·z^-2) by evaluating y[n] = x[n-2] + c·(x[n] − y[n-2]) once per accepted sample. The coefficient c is fixed when the block is elaborated. It is one of two values that need no multiplier: 1/8 or 9/16. Each instance of the block therefore costs two 20-bit delay pairs, one subtractor, at most one shift-add, and one rounding adder.

Samples are 20-bit two's-complement words: one sign bit, two integer bits and 17 fraction bits, so 1.0 is 0x20000. Each arithmetic step has its own rounding rule:
- The difference x[n] − y[n-2] keeps 20 bits and wraps.
- The product is widened to 24 bits, so it loses no precision.
- The final sum is brought back to 20 bits with round-toward-zero.

Stages of this kind are normally placed in the two paths of a polyphase half-band filter.

A sample is taken on each clock where the valid input is high. The matching output appears one clock later with its own valid flag. A synchronous active-low clear empties the delay state.

Top module: `allpass_sa`

## Requirements
- R1: While the asynchronous reset rst_ni is low, y_o is 0 and out_valid_o is 0.
- R2: out_valid_o equals the value in_valid_i had at the previous rising clock edge, while clr_ni was high at that edge.
- R3: On a clock edge where in_valid_i is low, no delay state advances and y_o keeps its value, whatever x_i carries.
- R4: After an accepted sample x[n], y_o equals y[n] = x[n-2] + c·(x[n] − y[n-2]). The operands are 20-bit words with 17 fraction bits. The difference wraps to 20 bits. The product c·d is exact in 24 bits with 21 fraction bits. The sum x[n-2]·16 + c·d wraps to 24 bits and is reduced to 20 bits by rounding toward zero.
- R5: After a clear, the input sequence 0x20000 (1.0), 0, 0 produces these outputs. For c = 1/8 they are 0x04000, 0, 0x1F800. For c = 9/16 they are 0x12000, 0, 0x15E00.
- R6: When the 24-bit sum is negative and any of its 4 low bits is 1, the result is one LSB above the floor. For example, an input of −1 LSB after a clear gives y = 0, not −1.
- R7: When clr_ni is low at a clock edge, all four delay registers and out_valid_o become 0. This takes priority over in_valid_i.
- R8: With the coefficient parameter COEF set to COEF_EIGHTH (encoding 0), c = 1/8, built as an arithmetic right shift by 3. With COEF_NINE_16THS (encoding 1), c = 9/16, built as the sum of shifts by 1 and by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_ni | input | 1 | Synchronous active-low clear of the delay state |
| in_valid_i | input | 1 | Sample strobe; x_i is accepted when high |
| x_i | input | 20 | Input sample, two's complement, 17 fraction bits |
| out_valid_o | output | 1 | High for one clock when y_o holds a new sample |
| y_o | output | 20 | Output sample, same format as x_i |

## Verification
Both coefficient variants are driven with the same input patterns, and each pattern targets a different requirement:
- A unit impulse after a clear separates the feed-forward path from the recursion. Its first output exposes c, and its third output exposes 1 − c².
- Single-LSB inputs of both signs make the discarded product bits nonzero. Any rounding other than toward zero then changes the output.
- Full-range random samples exercise the wrap of the difference and of the 24-bit sum.
- Gaps in the valid strobe that carry junk data show whether the state really holds.
- A clear raised together with a valid sample shows that the clear wins.

// File: rtl/allpass_sa_pkg.sv
package allpass_sa_pkg;
  typedef enum logic {
    COEF_EIGHTH      = 1'b0,
    COEF_NINE_16THS  = 1'b1
  } coef_e;
endpackage

// File: rtl/ap_delay2.sv
module ap_delay2 #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q1_o,
  output logic [W-1:0] q2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1_o <= '0;
      q2_o <= '0;
    end else if (!clr_ni) begin
      q1_o <= '0;
      q2_o <= '0;
    end else if (en_i) begin
      q1_o <= d_i;
      q2_o <= q1_o;
    end
  end
endmodule

// File: rtl/ap_coef_mul.sv
module ap_coef_mul
  import allpass_sa_pkg::*;
#(
  parameter int    W    = 20,
  parameter int    PW   = 24,
  parameter coef_e COEF = COEF_EIGHTH
) (
  input  logic [W-1:0]  d_i,
  output logic [PW-1:0] p_o
);
  localparam int GUARD = PW - W;

  logic signed [PW-1:0] ext;
  assign ext = $signed({d_i, {GUARD{1'b0}}});

  generate
    if (COEF == COEF_EIGHTH) begin : g_eighth
      assign p_o = ext >>> 3;
    end else begin : g_nine_16ths
      logic signed [PW-1:0] half, sixteenth;
      assign half      = ext >>> 1;
      assign sixteenth = ext >>> 4;
      assign p_o       = half + sixteenth;
    end
  endgenerate
endmodule

// File: rtl/ap_rtz_add.sv
module ap_rtz_add #(
  parameter int W  = 20,
  parameter int PW = 24
) (
  input  logic [W-1:0]  a_i,
  input  logic [PW-1:0] b_i,
  output logic [W-1:0]  y_o
);
  localparam int GUARD = PW - W;

  logic [PW-1:0] sum;
  logic          drop_any;
  logic          bump;

  assign sum      = {a_i, {GUARD{1'b0}}} + b_i;
  assign drop_any = |sum[GUARD-1:0];
  // negative values move up by one LSB when bits are dropped -> toward zero
  assign bump     = sum[PW-1] & drop_any;
  assign y_o      = sum[PW-1:GUARD] + {{(W-1){1'b0}}, bump};
endmodule

// File: rtl/allpass_sa.sv
module allpass_sa
  import allpass_sa_pkg::*;
#(
  parameter int    W     = 20,
  parameter int    GUARD = 4,
  parameter coef_e COEF  = COEF_EIGHTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         in_valid_i,
  input  logic [19:0]  x_i,
  output logic         out_valid_o,
  output logic [19:0]  y_o
);
  localparam int PW = W + GUARD;

  logic [W-1:0]  x_d1, x_d2, y_d1, y_d2;
  logic [W-1:0]  diff, y_next;
  logic [PW-1:0] prod;

  ap_delay2 #(.W(W)) u_xdly (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .en_i(in_valid_i),
    .d_i(x_i), .q1_o(x_d1), .q2_o(x_d2)
  );

  // difference via inverted operand plus carry-in, kept at W bits
  assign diff = x_i + (~y_d2) + W'(1);

  ap_coef_mul #(.W(W), .PW(PW), .COEF(COEF)) u_mul (
    .d_i(diff), .p_o(prod)
  );

  ap_rtz_add #(.W(W), .PW(PW)) u_add (
    .a_i(x_d2), .b_i(prod), .y_o(y_next)
  );

  ap_delay2 #(.W(W)) u_ydly (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .en_i(in_valid_i),
    .d_i(y_next), .q1_o(y_d1), .q2_o(y_d2)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_valid_o <= 1'b0;
    else if (!clr_ni) out_valid_o <= 1'b0;
    else              out_valid_o <= in_valid_i;
  end

  assign y_o = y_d1;
endmodule

// File: rtl/allpass_sa_chk.sv
module allpass_sa_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clr_ni,
  input logic        in_valid_i,
  input logic [19:0] x_i,
  input logic        out_valid_o,
  input logic [19:0] y_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_r1: assert (y_o == 20'd0 && !out_valid_o);
    end
  end

  p_valid_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && in_valid_i) |=> out_valid_o);

  p_valid_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !in_valid_i) |=> $stable(y_o));

  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (y_o == 20'd0 && !out_valid_o));

  // R6: right after a clear, a one-LSB input rounds to zero in both signs
  p_rtz_small_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clr_ni) && clr_ni && in_valid_i && (x_i == 20'hFFFFF || x_i == 20'h00001))
    |=> (y_o == 20'd0));
endmodule

bind allpass_sa allpass_sa_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .in_valid_i(in_valid_i),
  .x_i(x_i), .out_valid_o(out_valid_o), .y_o(y_o)
);

// File: tb/allpass_sa_test.sv
module allpass_sa_test;
  import allpass_sa_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        in_valid = 1'b0;
  logic [19:0] x_in = '0;
  logic        ov_a, ov_b;
  logic [19:0] y_a, y_b;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  allpass_sa #(.COEF(COEF_EIGHTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .in_valid_i(in_valid),
    .x_i(x_in), .out_valid_o(ov_a), .y_o(y_a)
  );

  allpass_sa #(.COEF(COEF_NINE_16THS)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .in_valid_i(in_valid),
    .x_i(x_in), .out_valid_o(ov_b), .y_o(y_b)
  );

  // reference state; index 0: c = 1/8 (2/16 in product units), 1: c = 9/16
  longint mx1[2], mx2[2], my1[2], my2[2];
  longint kmul[2] = '{2, 9};
  bit     exp_v;

  function automatic longint wrap(longint v, int n);
    longint m = longint'(1) << n;
    longint r = v % m;
    if (r < 0) r += m;
    if (r >= m / 2) r -= m;
    return r;
  endfunction

  function automatic longint sx20(logic [19:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint ref_out(longint x, longint x2, longint y2, longint k);
    longint d = wrap(x - y2, 20);
    longint p = d * k;                  // exact, 21 fraction bits
    longint s = wrap(x2 * 16 + p, 24);
    return wrap(s / 16, 20);            // integer division truncates toward zero
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 2; i++) begin
      mx1[i] = 0; mx2[i] = 0; my1[i] = 0; my2[i] = 0;
    end
    exp_v = 1'b0;
  endtask

  task automatic step(bit v, logic [19:0] x, bit clr, string tag);
    @(negedge clk);
    in_valid = v;
    x_in     = x;
    clr_n    = !clr;
    @(posedge clk);
    if (clr) model_clear();
    else begin
      exp_v = v;
      if (v) begin
        for (int i = 0; i < 2; i++) begin
          longint y = ref_out(sx20(x), mx2[i], my2[i], kmul[i]);
          mx2[i] = mx1[i]; mx1[i] = sx20(x);
          my2[i] = my1[i]; my1[i] = y;
        end
      end
    end
    #1;
    chk(ov_a == exp_v, "R2", ov_a, exp_v);
    chk(ov_b == exp_v, "R2", ov_b, exp_v);
    chk(sx20(y_a) == my1[0], clr ? "R7" : (v ? tag : "R3"), sx20(y_a), my1[0]);
    chk(sx20(y_b) == my1[1], clr ? "R7" : (v ? tag : "R3"), sx20(y_b), my1[1]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(y_a == 0 && !ov_a, "R1", sx20(y_a), 0);
    chk(y_b == 0 && !ov_b, "R1", sx20(y_b), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5/R8: impulse after clear, fixed expected values
    step(1'b0, 20'h0, 1'b1, "R7");
    step(1'b1, 20'h20000, 1'b0, "R5");
    chk(y_a == 20'h04000, "R5", sx20(y_a), 'h04000);
    chk(y_b == 20'h12000, "R8", sx20(y_b), 'h12000);
    step(1'b1, 20'h0, 1'b0, "R5");
    chk(y_a == 20'h0 && y_b == 20'h0, "R5", sx20(y_a), 0);
    step(1'b1, 20'h0, 1'b0, "R5");
    chk(y_a == 20'h1F800, "R5", sx20(y_a), 'h1F800);
    chk(y_b == 20'h15E00, "R8", sx20(y_b), 'h15E00);
    for (int i = 0; i < 6; i++) step(1'b1, 20'h0, 1'b0, "R4");

    // R6: single-LSB inputs round toward zero
    step(1'b0, 20'h0, 1'b1, "R7");
    step(1'b1, 20'hFFFFF, 1'b0, "R6");
    chk(y_a == 20'h0 && y_b == 20'h0, "R6", sx20(y_b), 0);
    step(1'b0, 20'h0, 1'b1, "R7");
    step(1'b1, 20'h00001, 1'b0, "R6");
    for (int i = 0; i < 8; i++) step(1'b1, 20'hFFFF5 + 20'(i), 1'b0, "R6");

    // R3: valid gaps with junk data
    for (int i = 0; i < 5; i++) step(1'b0, 20'h5A5A5 ^ 20'(i * 977), 1'b0, "R3");
    step(1'b1, 20'h0FFFF, 1'b0, "R4");
    step(1'b0, 20'hABCDE, 1'b0, "R3");
    step(1'b1, 20'hE0001, 1'b0, "R4");

    // R4: full-range random stream with sporadic gaps
    for (int i = 0; i < 400; i++) begin
      logic [19:0] r = 20'($urandom);
      step(($urandom % 5) != 0, r, 1'b0, "R4");
    end

    // R7: clear wins over a valid sample
    step(1'b1, 20'h7FFFF, 1'b1, "R7");
    step(1'b1, 20'h20000, 1'b0, "R5");
    chk(y_a == 20'h04000, "R5", sx20(y_a), 'h04000);
    step(1'b1, 20'h0, 1'b0, "R4");
    step(1'b1, 20'h0, 1'b0, "R4");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule